// File: doc/BRIEF.md
# Streaming Gaussian Noise Generator

This block produces a continuous stream of approximately normally distributed samples. Two independent 16-bit shift-register generators supply uniform values each cycle. A Box-Muller stage turns each pair of uniforms into two correlated-free samples using lookup tables for the square root of the negated logarithm and for one period of sine and cosine. A lag stage then adds each new sample to the one that came before it on the same channel. The last stage stores both results side by side in a wrapping on-chip sample buffer, which a consumer reads through a synchronous read port.

The pipeline advances on every clock where `en` is high and `seed_load` is low, and freezes completely otherwise. Software-free reseeding is done through the seed port. A zero seed would lock a shift register, so it is refused. `valid` tells the consumer that the pipeline has filled and that buffer writes have begun.

Top module: `gauss_noise_gen`

## Requirements
- R1: Generator A is a 16-bit left-shifting register whose new bit 0 is the XOR of state bits 15, 13, 12 and 10. Generator B uses bits 15, 14, 12 and 3. Each shifts once per advancing clock, and its state is the uniform value u1 (A) or u2 (B).
- R2: Reset loads A with SEED_A (default 16'hACE1) and B with SEED_B (default 16'h1D2B). While `seed_load` is high, A takes `seed_a` and B takes `seed_b` and nothing else in the pipeline moves. A seed of zero leaves that register unchanged.
- R3: Entry k of the magnitude table is round(sqrt(-ln((k+0.5)/256))·4096), unsigned, and is indexed by u1[15:8]. Entries of the sine and cosine tables are round(sin or cos(2π(k+0.5)/256)·16384), signed, and are indexed by u2[15:8]. x1 = (mag·sin)>>>14 and x2 = (mag·cos)>>>14, rounded toward minus infinity and kept as 16-bit two's complement.
- R4: Each channel outputs its new x plus the x it received at the previous advance. The held value is zero after reset, so the first output pair equals the first x pair.
- R5: `valid` is low after reset and goes high after the third advancing clock. When the pipeline does not advance, neither the generators nor `valid` change.
- R6: Buffer writes happen only on advancing clocks with `valid` high. Write number i (counting from 0) stores channel 1 at address 2·(i mod NUM_SAMPLES/2) and channel 2 at the next address. Later writes overwrite earlier ones after a wrap.
- R7: `rd_data` presents the buffer word at `rd_addr` one clock after the address is applied.
- R8: Reset clears the write position to address 0 and drives `valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Pipeline advance enable |
| seed_load | input | 1 | Load seeds; holds the pipeline this cycle |
| seed_a | input | 16 | Seed for generator A (zero refused) |
| seed_b | input | 16 | Seed for generator B (zero refused) |
| rd_addr | input | $clog2(NUM_SAMPLES) | Buffer read address |
| rd_data | output | 16 | Buffer word, Q4.12, one cycle after address |
| valid | output | 1 | Pipeline filled; writes in progress |

## Verification
The main function is driven from several seed pairs, including the all-ones and single-bit seeds that sit at extreme codes of both tables. Zero seeds on one side show whether refusal keeps the reset seed. A run of more than half the buffer depth in pairs separates correct wrapping from a linear or off-by-one index. Runs with `en` dropped every third cycle must leave exactly the same buffer contents as continuous runs, which shows that a stall neither skips nor repeats a generator step. The first pair read after reset reveals whether the held values started at zero.

// File: rtl/gng_pkg.sv
package gng_pkg;
  localparam int U_W       = 16;
  localparam int S_W       = 16;
  localparam int T_W       = 16;
  localparam int TBL_AW    = 8;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int MAG_FRAC  = 12;
  localparam int TRIG_FRAC = 14;
  localparam int PROD_W    = 2 * T_W + 1;
  localparam real TWO_PI   = 6.283185307179586;

  typedef enum logic [1:0] {
    TBL_SQRTLN = 2'd0,
    TBL_SIN    = 2'd1,
    TBL_COS    = 2'd2
  } tbl_kind_e;

  // Table entries are sampled at bin midpoints so the log argument is never zero.
  function automatic logic [T_W-1:0] tbl_entry(tbl_kind_e kind, int k);
    real u;
    real v;
    u = (real'(k) + 0.5) / real'(TBL_DEPTH);
    case (kind)
      TBL_SQRTLN: v = $sqrt(-$ln(u)) * real'(1 << MAG_FRAC);
      TBL_SIN:    v = $sin(TWO_PI * u) * real'(1 << TRIG_FRAC);
      default:    v = $cos(TWO_PI * u) * real'(1 << TRIG_FRAC);
    endcase
    return T_W'($rtoi($floor(v + 0.5)));
  endfunction
endpackage

// File: rtl/gng_lfsr.sv
module gng_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (load) begin
      if (load_val != '0) state <= load_val;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end
endmodule

// File: rtl/gng_rom.sv
module gng_rom
  import gng_pkg::*;
#(
  parameter tbl_kind_e KIND = TBL_SIN
) (
  input  logic [TBL_AW-1:0] addr,
  output logic [T_W-1:0]    data
);
  logic [T_W-1:0] mem [TBL_DEPTH];

  initial begin
    for (int k = 0; k < TBL_DEPTH; k++) mem[k] = tbl_entry(KIND, k);
  end

  assign data = mem[addr];
endmodule

// File: rtl/gng_boxmuller.sv
module gng_boxmuller
  import gng_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                in_vld,
  input  logic [U_W-1:0]      u1,
  input  logic [U_W-1:0]      u2,
  output logic [1:0][S_W-1:0] x,
  output logic                out_vld
);
  logic [T_W-1:0]      mag;
  logic [1:0][S_W-1:0] x_next;

  gng_rom #(.KIND(TBL_SQRTLN)) u_rom_mag (
    .addr (u1[U_W-1 -: TBL_AW]),
    .data (mag)
  );

  // One trig table and one multiplier per channel; the magnitude operand is shared.
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [T_W-1:0]           trig;
    logic signed [PROD_W-1:0] prod;

    gng_rom #(.KIND(c == 0 ? TBL_SIN : TBL_COS)) u_rom_trig (
      .addr (u2[U_W-1 -: TBL_AW]),
      .data (trig)
    );

    assign prod = PROD_W'($signed({1'b0, mag})) * PROD_W'($signed(trig));
    assign x_next[c] = prod[TRIG_FRAC +: S_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x       <= '0;
      out_vld <= 1'b0;
    end else if (adv) begin
      x       <= x_next;
      out_vld <= in_vld;
    end
  end
endmodule

// File: rtl/gng_lagsum.sv
module gng_lagsum
  import gng_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                in_vld,
  input  logic [1:0][S_W-1:0] x,
  output logic [1:0][S_W-1:0] y,
  output logic                out_vld
);
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [S_W-1:0] held;
    logic [S_W-1:0] sum_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        held  <= '0;
        sum_q <= '0;
      end else if (adv && in_vld) begin
        sum_q <= x[c] + held;
        held  <= x[c];
      end
    end

    assign y[c] = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst)      out_vld <= 1'b0;
    else if (adv) out_vld <= in_vld;
  end
endmodule

// File: rtl/gng_sample_buf.sv
module gng_sample_buf
  import gng_pkg::*;
#(
  parameter int NUM_SAMPLES = 64,
  localparam int HALF = NUM_SAMPLES / 2,
  localparam int AW   = $clog2(NUM_SAMPLES),
  localparam int PW   = $clog2(HALF)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0][S_W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [S_W-1:0]      rd_data,
  output logic [PW-1:0]       wr_pair
);
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic [1:0][S_W-1:0] rd_word;
  logic                sel_q;

  // Even addresses live in bank 0 and odd ones in bank 1: one write port per bank.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [S_W-1:0] bank [HALF];
    logic [S_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en) bank[wr_pair] <= wr_data[b];
    end

    always_ff @(posedge clk) begin
      rd_q <= bank[rd_addr[AW-1:1]];
    end

    assign rd_word[b] = rd_q;
  end

  always_ff @(posedge clk) begin
    sel_q <= rd_addr[0];
  end

  assign rd_data = sel_q ? rd_word[1] : rd_word[0];

  always_ff @(posedge clk) begin
    if (rst)        wr_pair <= '0;
    else if (wr_en) wr_pair <= (wr_pair == LAST) ? '0 : wr_pair + 1'b1;
  end
endmodule

// File: rtl/gauss_noise_gen.sv
module gauss_noise_gen
  import gng_pkg::*;
#(
  parameter int           NUM_SAMPLES = 64,
  parameter logic [15:0]  SEED_A      = 16'hACE1,
  parameter logic [15:0]  SEED_B      = 16'h1D2B,
  parameter logic [15:0]  TAPS_A      = 16'hB400,
  parameter logic [15:0]  TAPS_B      = 16'hD008,
  localparam int AW = $clog2(NUM_SAMPLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          seed_load,
  input  logic [15:0]   seed_a,
  input  logic [15:0]   seed_b,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          valid
);
  localparam int PW = $clog2(NUM_SAMPLES / 2);

  logic                adv;
  logic [U_W-1:0]      u1;
  logic [U_W-1:0]      u2;
  logic                v1;
  logic                v2;
  logic                v3;
  logic [1:0][S_W-1:0] x;
  logic [1:0][S_W-1:0] y;
  logic                wr_en;
  logic [PW-1:0]       wr_pair;

  assign adv = en & ~seed_load;

  // Stage 1: uniform sources
  gng_lfsr #(.W(U_W), .TAPS(TAPS_A), .SEED(SEED_A)) u_lfsr_a (
    .clk      (clk),
    .rst      (rst),
    .step     (adv),
    .load     (seed_load),
    .load_val (seed_a),
    .state    (u1)
  );

  gng_lfsr #(.W(U_W), .TAPS(TAPS_B), .SEED(SEED_B)) u_lfsr_b (
    .clk      (clk),
    .rst      (rst),
    .step     (adv),
    .load     (seed_load),
    .load_val (seed_b),
    .state    (u2)
  );

  always_ff @(posedge clk) begin
    if (rst)      v1 <= 1'b0;
    else if (adv) v1 <= 1'b1;
  end

  // Stage 2: Box-Muller pair
  gng_boxmuller u_bm (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .in_vld  (v1),
    .u1      (u1),
    .u2      (u2),
    .x       (x),
    .out_vld (v2)
  );

  // Stage 3: current plus previous sample per channel
  gng_lagsum u_lag (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .in_vld  (v2),
    .x       (x),
    .y       (y),
    .out_vld (v3)
  );

  assign valid = v3;
  assign wr_en = adv & v3;

  // Stage 4: paired writes into the wrapping buffer
  gng_sample_buf #(.NUM_SAMPLES(NUM_SAMPLES)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (y),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_pair (wr_pair)
  );
endmodule

// File: rtl/gauss_noise_gen_chk.sv
module gauss_noise_gen_chk #(
  parameter int NUM_SAMPLES = 64,
  localparam int PW = $clog2(NUM_SAMPLES / 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          seed_load,
  input logic          valid,
  input logic [15:0]   u1,
  input logic [15:0]   u2,
  input logic          wr_en,
  input logic [PW-1:0] wr_pair
);
  localparam logic [PW-1:0] LAST = PW'(NUM_SAMPLES / 2 - 1);

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (u1 != 16'h0) && (u2 != 16'h0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en && !seed_load |=> $stable(u1) && $stable(u2) && $stable(valid)); // R5

  AST_SEED_HOLDS_VALID: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> $stable(valid)); // R2

  AST_VALID_AFTER_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(en && !seed_load)); // R5

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> valid && en && !seed_load); // R6

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_pair != LAST) |=> wr_pair == $past(wr_pair) + 1'b1); // R6

  AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_pair == LAST) |=> wr_pair == '0); // R6

  AST_PAIR_STILL: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_pair)); // R6
endmodule

bind gauss_noise_gen gauss_noise_gen_chk #(.NUM_SAMPLES(NUM_SAMPLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .seed_load (seed_load),
  .valid     (valid),
  .u1        (u1),
  .u2        (u2),
  .wr_en     (wr_en),
  .wr_pair   (wr_pair)
);

// File: tb/gauss_noise_gen_tb.sv
`timescale 1ns/1ps
module gauss_noise_gen_tb;
  localparam int N    = 64;
  localparam int HALF = N / 2;
  localparam int AW   = $clog2(N);
  localparam logic [15:0] DEF_A  = 16'hACE1;
  localparam logic [15:0] DEF_B  = 16'h1D2B;
  localparam logic [15:0] MASK_A = 16'hB400;
  localparam logic [15:0] MASK_B = 16'hD008;

  typedef struct packed {
    logic [15:0] sa;
    logic [15:0] sb;
    logic [7:0]  pairs;
    logic        stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 16'h0001, 8'd10, 1'b0},
    '{16'hACE1, 16'h5A5A, 8'd20, 1'b1},
    '{16'h0000, 16'h1234, 8'd8,  1'b0},
    '{16'hFFFF, 16'h8001, 8'd40, 1'b0},
    '{16'h7F3C, 16'h0000, 8'd12, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          seed_load = 1'b0;
  logic [15:0]   seed_a = '0;
  logic [15:0]   seed_b = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          valid;

  int n_chk = 0;
  int n_bad = 0;
  int ftab [256];
  int stab [256];
  int ctab [256];
  logic [15:0] exp_buf [N];
  int          exp_pair [N];

  always #2 clk = ~clk;

  gauss_noise_gen #(
    .NUM_SAMPLES (N),
    .SEED_A      (DEF_A),
    .SEED_B      (DEF_B),
    .TAPS_A      (MASK_A),
    .TAPS_B      (MASK_B)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seed_load (seed_load),
    .seed_a    (seed_a),
    .seed_b    (seed_b),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .valid     (valid)
  );

  function automatic logic [15:0] nxt(logic [15:0] s, logic [15:0] m);
    return {s[14:0], ^(s & m)};
  endfunction

  function automatic int rnd(real v);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic logic [15:0] mulq(int f, int t);
    longint p;
    p = longint'(f) * longint'(t);
    p = p >>> 14;
    return p[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; seed_load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R8 valid low after reset", {15'b0, valid}, 16'h0);
  endtask

  task automatic run_vector(int vi, vec_t vv);
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] x1;
    logic [15:0] x2;
    logic [15:0] p1;
    logic [15:0] p2;
    int np;
    int e;
    int c;
    int nread;
    string tag;
    np = int'(vv.pairs);
    do_reset();
    // R2: load seeds with the pipeline idle; a zero seed keeps the reset seed
    seed_a = vv.sa; seed_b = vv.sb; seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check("R2 seed load leaves valid low", {15'b0, valid}, 16'h0);
    a = (vv.sa != 16'h0) ? vv.sa : DEF_A;
    b = (vv.sb != 16'h0) ? vv.sb : DEF_B;
    p1 = '0; p2 = '0;
    for (int k = 0; k < N; k++) begin exp_buf[k] = 'x; exp_pair[k] = -1; end
    for (int j = 0; j < np; j++) begin
      a = nxt(a, MASK_A);
      b = nxt(b, MASK_B);
      x1 = mulq(ftab[a[15:8]], stab[b[15:8]]);
      x2 = mulq(ftab[a[15:8]], ctab[b[15:8]]);
      exp_buf[2 * (j % HALF)]     = x1 + p1;
      exp_buf[2 * (j % HALF) + 1] = x2 + p2;
      exp_pair[2 * (j % HALF)]     = j;
      exp_pair[2 * (j % HALF) + 1] = j;
      p1 = x1; p2 = x2;
    end
    // Pair j is written on advance j+4, so np+3 advances write np pairs.
    e = 0; c = 0;
    while (e < np + 3) begin
      en = !(vv.stall && (c % 3 == 2));
      @(negedge clk);
      if (en) e++;
      c++;
      check($sformatf("R5 valid vec%0d adv%0d", vi, e), {15'b0, valid},
            {15'b0, (e >= 3)});
    end
    en = 1'b0;
    nread = (2 * np < N) ? 2 * np : N;
    for (int p = 0; p < nread; p++) begin
      rd_addr = AW'(p);
      @(negedge clk);
      if (exp_pair[p] == 0)
        tag = $sformatf("R4 R1 R2 R3 R7 first pair vec%0d addr%0d", vi, p);
      else if (np > HALF)
        tag = $sformatf("R6 R3 R7 wrapped vec%0d addr%0d", vi, p);
      else
        tag = $sformatf("R1 R2 R3 R6 R7 vec%0d addr%0d", vi, p);
      check(tag, rd_data, exp_buf[p]);
    end
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin
      real u;
      u = (real'(k) + 0.5) / 256.0;
      ftab[k] = rnd($sqrt(-$ln(u)) * 4096.0);
      stab[k] = rnd($sin(6.283185307179586 * u) * 16384.0);
      ctab[k] = rnd($cos(6.283185307179586 * u) * 16384.0);
    end
    repeat (3) @(negedge clk);
    check("R8 valid low in reset", {15'b0, valid}, 16'h0);
    for (int vi = 0; vi < NV; vi++) run_vector(vi, VEC[vi]);
    // Directed: enable held low must never fill the pipeline
    do_reset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R5 no fill while disabled", {15'b0, valid}, 16'h0);
    end
    // Directed: seed_load with en high still holds the pipeline
    seed_a = 16'h2222; seed_b = 16'h3333;
    en = 1'b1; seed_load = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 seed load holds pipeline", {15'b0, valid}, 16'h0);
    seed_load = 1'b0; en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule